// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches recent virtual-to-physical page translations for a processor pipeline. Instruction fetch, loads and stores all use it. It is direct-mapped: the low bits of the virtual page number select one slot. Each slot holds a single physical page number that all access types share. Each slot also keeps three independent tags, one for each access type. A page can therefore be usable for loads while the same slot still needs a full translation for stores or fetches.

Each tag carries one extra bit that marks the page as needing trigger inspection. Load and store lookups ignore that bit. A fetch lookup hits only when the bit is set. This lets the surrounding logic send every such fetch down its slow path on purpose.

The page-table walker, the protection checker and the trigger logic all sit outside the block. Their results arrive on the refill port as plain flags. A refill always updates the shared page number unless privilege modification is active. It installs its own tag only when the protection flags say the whole page is uniform. Any sibling tag in the same slot that names a different page is invalidated.

Top module: `split_tag_tlb`

## Requirements
- R1: The slot index is the low log2(ENTRIES) bits of the virtual page number. Every access type at a slot reads the one shared physical page number stored there.
- R2: A load lookup (code 1) or a store lookup (code 2) hits when the virtual page field of that type's tag equals the looked-up page. The trigger bit is ignored. Code 3 behaves as a load for both lookup and refill.
- R3: A fetch lookup (code 0) hits only when the fetch tag holds the trigger bit set and the exact looked-up page.
- R4: A refill that is not suppressed always writes the physical page into its slot. It writes the tag of its own access type, as the trigger bit followed by the page, only when the uniform-protection input is 1.
- R5: On a refill that is not suppressed, each tag at the slot whose page field differs from the refill page becomes invalid (all ones). A tag whose page field matches keeps its value, trigger bit included.
- R6: A refill with the privilege-modify input at 1 changes no tag and no data.
- R7: Reset and flush set every tag of all three arrays to all ones. When flush and a refill occur in the same cycle, flush wins and the refill is lost.
- R8: Lookup is combinational. On a miss the physical page output is zero. A refill or flush becomes visible to lookups from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, same effect as flush |
| flush_i | input | 1 | Invalidate every tag |
| lk_vpn_i | input | 27 | Lookup virtual page number |
| lk_kind_i | input | 2 | Lookup access type: 0 fetch, 1 load, 2 store, 3 load |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | 44 | Physical page on hit, zero on miss |
| rf_valid_i | input | 1 | Refill request this cycle |
| rf_vpn_i | input | 27 | Refill virtual page number |
| rf_ppn_i | input | 44 | Refill physical page number |
| rf_kind_i | input | 2 | Refill access type, same coding as lookup |
| rf_trig_i | input | 1 | Set the trigger bit in the installed tag |
| rf_uniform_i | input | 1 | Whole page lies under one protection region |
| rf_privmod_i | input | 1 | Privilege modification active: suppress the refill |

## Verification
The bench uses the default build: 16 slots, a 27-bit virtual page and a 44-bit physical page. It draws virtual pages from 64 values that share only 16 slots. Each slot is therefore contested by four pages, so sibling invalidation, aliasing misses and same-page tag retention all happen often. The small slot count also lets a few directed refills reach every combination of access type, trigger bit, uniform flag and suppression on a single slot.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    localparam int NUM_KINDS = 3;

    // Code 3 is folded onto the load path.
    function automatic logic [1:0] kind_slot(input logic [1:0] code);
        return (code == 2'd3) ? 2'd1 : code;
    endfunction

endpackage

// File: rtl/stlb_refill_ctl.sv
module stlb_refill_ctl
    import stlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 27,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  logic                 rf_valid_i,
    input  logic [VPN_W-1:0]     rf_vpn_i,
    input  logic [1:0]           rf_kind_i,
    input  logic                 rf_uniform_i,
    input  logic                 rf_privmod_i,
    output logic                 go_o,
    output logic                 data_we_o,
    output logic [NUM_KINDS-1:0] install_o,
    output logic [IDX_W-1:0]     wr_idx_o
);
    logic [1:0] slot;

    always_comb begin
        slot      = kind_slot(rf_kind_i);
        go_o      = rf_valid_i && !rf_privmod_i && !flush_i;
        data_we_o = go_o;
        wr_idx_o  = rf_vpn_i[IDX_W-1:0];
        install_o = '0;
        if (go_o && rf_uniform_i)
            install_o[slot] = 1'b1;
    end

    // R4: at most one tag array installs per refill
    a_r4_single_install: assert property (@(posedge clk) disable iff (rst)
        $onehot0(install_o));

    // R6: a suppressed refill installs nothing
    a_r6_privmod_quiet: assert property (@(posedge clk) disable iff (rst)
        (rf_valid_i && rf_privmod_i) |-> (install_o == '0 && !data_we_o));
endmodule

// File: rtl/stlb_tag_bank.sv
module stlb_tag_bank #(
    parameter int ENTRIES     = 16,
    parameter int VPN_W       = 27,
    parameter bit FETCH_EXACT = 1'b0,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int TAG_W      = VPN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             go_i,
    input  logic             install_i,
    input  logic             trig_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [VPN_W-1:0] wr_vpn_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    output logic             hit_o
);
    logic [TAG_W-1:0] tags [ENTRIES];
    logic [TAG_W-1:0] rd_tag;
    logic [TAG_W-1:0] wr_old;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            for (int i = 0; i < ENTRIES; i++)
                tags[i] <= '1;
        end else if (go_i) begin
            if (install_i)
                tags[wr_idx_i] <= {trig_i, wr_vpn_i};
            else if (tags[wr_idx_i][VPN_W-1:0] != wr_vpn_i)
                tags[wr_idx_i] <= '1;
        end
    end

    assign rd_tag = tags[lk_vpn_i[IDX_W-1:0]];
    assign wr_old = tags[wr_idx_i];

    generate
        if (FETCH_EXACT) begin : g_exact
            assign hit_o = (rd_tag == {1'b1, lk_vpn_i});
        end else begin : g_masked
            assign hit_o = (rd_tag[VPN_W-1:0] == lk_vpn_i);
        end
    endgenerate

    // R5: a sibling tag naming another page is dropped
    a_r5_sibling_kill: assert property (@(posedge clk) disable iff (rst)
        (go_i && !flush_i && !install_i && wr_old[VPN_W-1:0] != wr_vpn_i)
        |=> (tags[$past(wr_idx_i)] == '1));

    // R4: an installing refill leaves exactly its tag behind
    a_r4_tag_written: assert property (@(posedge clk) disable iff (rst)
        (go_i && !flush_i && install_i)
        |=> (tags[$past(wr_idx_i)] == {$past(trig_i), $past(wr_vpn_i)}));
endmodule

// File: rtl/stlb_data_bank.sv
module stlb_data_bank #(
    parameter int ENTRIES = 16,
    parameter int PPN_W   = 44,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [PPN_W-1:0] wr_ppn_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [PPN_W-1:0] rd_ppn_o
);
    logic [PPN_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                mem[i] <= '0;
        end else if (we_i) begin
            mem[wr_idx_i] <= wr_ppn_i;
        end
    end

    assign rd_ppn_o = mem[rd_idx_i];

    // R4: the shared page word follows every unsuppressed refill
    a_r4_data_written: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mem[$past(wr_idx_i)] == $past(wr_ppn_i)));
endmodule

// File: rtl/split_tag_tlb.sv
module split_tag_tlb
    import stlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 27,
    parameter int PPN_W   = 44,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    input  logic [1:0]       lk_kind_i,
    output logic             lk_hit_o,
    output logic [PPN_W-1:0] lk_ppn_o,
    input  logic             rf_valid_i,
    input  logic [VPN_W-1:0] rf_vpn_i,
    input  logic [PPN_W-1:0] rf_ppn_i,
    input  logic [1:0]       rf_kind_i,
    input  logic             rf_trig_i,
    input  logic             rf_uniform_i,
    input  logic             rf_privmod_i
);
    logic                 go;
    logic                 data_we;
    logic [NUM_KINDS-1:0] install;
    logic [IDX_W-1:0]     wr_idx;
    logic [NUM_KINDS-1:0] bank_hit;
    logic [PPN_W-1:0]     slot_ppn;
    logic                 sel_hit;

    stlb_refill_ctl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .flush_i      (flush_i),
        .rf_valid_i   (rf_valid_i),
        .rf_vpn_i     (rf_vpn_i),
        .rf_kind_i    (rf_kind_i),
        .rf_uniform_i (rf_uniform_i),
        .rf_privmod_i (rf_privmod_i),
        .go_o         (go),
        .data_we_o    (data_we),
        .install_o    (install),
        .wr_idx_o     (wr_idx)
    );

    generate
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
            stlb_tag_bank #(
                .ENTRIES     (ENTRIES),
                .VPN_W       (VPN_W),
                .FETCH_EXACT (k == int'(ACC_FETCH))
            ) u_tags (
                .clk       (clk),
                .rst       (rst),
                .flush_i   (flush_i),
                .go_i      (go),
                .install_i (install[k]),
                .trig_i    (rf_trig_i),
                .wr_idx_i  (wr_idx),
                .wr_vpn_i  (rf_vpn_i),
                .lk_vpn_i  (lk_vpn_i),
                .hit_o     (bank_hit[k])
            );
        end
    endgenerate

    stlb_data_bank #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .we_i     (data_we),
        .wr_idx_i (wr_idx),
        .wr_ppn_i (rf_ppn_i),
        .rd_idx_i (lk_vpn_i[IDX_W-1:0]),
        .rd_ppn_o (slot_ppn)
    );

    assign sel_hit  = bank_hit[kind_slot(lk_kind_i)];
    assign lk_hit_o = sel_hit;
    assign lk_ppn_o = sel_hit ? slot_ppn : '0;

    // R7: nothing hits on the cycle after a flush
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(flush_i) && lk_vpn_i != '1) |-> !lk_hit_o);

    // R8: a miss never exposes a page number
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_hit_o |-> (lk_ppn_o == '0));
endmodule

// File: tb/split_tag_tlb_test.sv
module split_tag_tlb_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENT   = 16;
    localparam int VW    = 27;
    localparam int PW    = 44;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush_i = 1'b0;
    logic [VW-1:0] lk_vpn_i = '0;
    logic [1:0]    lk_kind_i = '0;
    logic          lk_hit_o;
    logic [PW-1:0] lk_ppn_o;
    logic          rf_valid_i = 1'b0;
    logic [VW-1:0] rf_vpn_i = '0;
    logic [PW-1:0] rf_ppn_i = '0;
    logic [1:0]    rf_kind_i = '0;
    logic          rf_trig_i = 1'b0;
    logic          rf_uniform_i = 1'b0;
    logic          rf_privmod_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [VW:0]   mtag [3][ENT];
    logic [PW-1:0] mdat [ENT];

    always #(CLK_PERIOD/2) clk = ~clk;

    split_tag_tlb uut (.*);

    function automatic int slot_of(input logic [1:0] k);
        return (k == 2'd3) ? 1 : int'(k);
    endfunction

    function automatic bit m_hit(input logic [VW-1:0] v, input logic [1:0] k);
        int s = slot_of(k);
        logic [3:0] ix = v[3:0];
        if (s == 0) return mtag[0][ix] == {1'b1, v};
        return mtag[s][ix][VW-1:0] == v;
    endfunction

    task automatic m_reset();
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < ENT; i++) mtag[s][i] = '1;
        for (int i = 0; i < ENT; i++) mdat[i] = '0;
    endtask

    task automatic m_apply();
        logic [3:0] ix = rf_vpn_i[3:0];
        if (flush_i) begin
            for (int s = 0; s < 3; s++)
                for (int i = 0; i < ENT; i++) mtag[s][i] = '1;
        end else if (rf_valid_i && !rf_privmod_i) begin
            for (int s = 0; s < 3; s++)
                if (mtag[s][ix][VW-1:0] != rf_vpn_i) mtag[s][ix] = '1;
            if (rf_uniform_i) mtag[slot_of(rf_kind_i)][ix] = {rf_trig_i, rf_vpn_i};
            mdat[ix] = rf_ppn_i;
        end
    endtask

    task automatic check(input string req, input logic [PW:0] act, input logic [PW:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lookup now (after a negedge), compare with model and with explicit expectation.
    task automatic look(input string req, input logic [VW-1:0] v, input logic [1:0] k,
                        input bit eh, input logic [PW-1:0] ep);
        lk_vpn_i = v; lk_kind_i = k;
        #1;
        check(req, {lk_hit_o, lk_ppn_o}, {eh, eh ? ep : {PW{1'b0}}});
    endtask

    // One clock with the given refill/flush, model updated alongside.
    task automatic step(input bit fl, input bit val, input logic [VW-1:0] v,
                        input logic [PW-1:0] p, input logic [1:0] k,
                        input bit tr, input bit un, input bit pm);
        flush_i = fl; rf_valid_i = val; rf_vpn_i = v; rf_ppn_i = p;
        rf_kind_i = k; rf_trig_i = tr; rf_uniform_i = un; rf_privmod_i = pm;
        @(posedge clk);
        m_apply();
        @(negedge clk);
        flush_i = 1'b0; rf_valid_i = 1'b0;
    endtask

    function automatic logic [VW-1:0] pick_vpn();
        return VW'({$urandom_range(0, 3), 4'($urandom_range(0, 15))}) + VW'(32'h100 * 0);
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [VW-1:0] a, b;
        void'($urandom(32'd4242));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // Reset state: all misses (R7, R8)
        look("R7 reset empty load", 27'h5, 2'd1, 0, '0);
        look("R7 reset empty fetch", 27'h0, 2'd0, 0, '0);
        look("R8 reset store ppn zero", 27'h3a, 2'd2, 0, '0);

        a = 27'h123;  // slot 3
        b = 27'h213;  // slot 3, other page
        // Fetch install without trigger bit: fetch misses (R3), data shared (R1)
        step(0, 1, a, 44'hAAA, 2'd0, 0, 1, 0);
        look("R3 fetch needs flag", a, 2'd0, 0, '0);
        look("R2 load no tag yet", a, 2'd1, 0, '0);
        // Fetch install with trigger bit: hits
        step(0, 1, a, 44'hBBB, 2'd0, 1, 1, 0);
        look("R3 fetch flagged hit", a, 2'd0, 1, 44'hBBB);
        // Load with trigger bit: load ignores flag (R2); code 3 acts as load
        step(0, 1, a, 44'hCCC, 2'd1, 1, 1, 0);
        look("R2 load flag ignored", a, 2'd1, 1, 44'hCCC);
        look("R2 code3 as load", a, 2'd3, 1, 44'hCCC);
        look("R1 fetch shares data", a, 2'd0, 1, 44'hCCC);
        look("R1 other page same slot", b, 2'd1, 0, '0);
        // Non-uniform store refill: data written, no store tag (R4); siblings same page kept (R5)
        step(0, 1, a, 44'hDDD, 2'd2, 0, 0, 0);
        look("R4 store tag not installed", a, 2'd2, 0, '0);
        look("R4 data still written", a, 2'd1, 1, 44'hDDD);
        look("R5 same page fetch kept", a, 2'd0, 1, 44'hDDD);
        // Privilege modify: nothing changes (R6)
        step(0, 1, b, 44'hEEE, 2'd1, 0, 1, 1);
        look("R6 privmod no tag", b, 2'd1, 0, '0);
        look("R6 privmod no data", a, 2'd1, 1, 44'hDDD);
        // Conflicting refill kills siblings (R5)
        step(0, 1, b, 44'hFFF, 2'd2, 0, 1, 0);
        look("R5 sibling load killed", a, 2'd1, 0, '0);
        look("R5 sibling fetch killed", a, 2'd0, 0, '0);
        look("R4 new store tag", b, 2'd2, 1, 44'hFFF);
        // Flush beats refill in the same cycle (R7)
        step(1, 1, 27'h7, 44'h111, 2'd1, 0, 1, 0);
        look("R7 flush cleared", b, 2'd2, 0, '0);
        look("R7 refill lost to flush", 27'h7, 2'd1, 0, '0);
        // Visibility timing: not before the edge (R8)
        rf_valid_i = 1; rf_vpn_i = 27'h9; rf_ppn_i = 44'h222; rf_kind_i = 2'd1;
        rf_trig_i = 0; rf_uniform_i = 1; rf_privmod_i = 0;
        look("R8 not visible before edge", 27'h9, 2'd1, 0, '0);
        @(posedge clk); m_apply(); @(negedge clk); rf_valid_i = 0;
        look("R8 visible after edge", 27'h9, 2'd1, 1, 44'h222);

        // Random mix against the model
        for (int n = 0; n < 4000; n++) begin
            logic [VW-1:0] lv, rv;
            logic [1:0] lk;
            bit eh;
            lv = pick_vpn();
            lk = 2'($urandom_range(0, 3));
            rv = pick_vpn();
            eh = m_hit(lv, lk);
            look(slot_of(lk) == 0 ? "R3 random fetch" : "R2 random load/store",
                 lv, lk, eh, mdat[lv[3:0]]);
            step($urandom_range(0, 49) == 0, $urandom_range(0, 1) == 1, rv,
                 PW'({$urandom(), $urandom()}), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 4) != 0,
                 $urandom_range(0, 9) == 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule